// File: doc/BRIEF.md
# Ambient Light Serial Sample Reader

This block is the host side of a three-wire serial link to a read-only light-to-digital converter. When the surrounding logic pulses a start request, the reader drops the active-low select line. It then drives a burst of sixteen serial clock cycles, whose rate comes from the system clock through a parameterised half-period divider. From the incoming bit stream it picks out one 8-bit light reading. The reading is an unsigned brightness: 0 is darkest and 255 is brightest. The reader presents it on a result register together with a single-cycle valid strobe.

Each frame holds three zero bits, then the reading with the most significant bit first, then four zero bits, then one final bit. The reader checks the seven padding bits. If any of them is 1, it raises a framing-error flag in the same cycle as the strobe.

The result leaves as a strobe with no ready input. There is no back-pressure: a consumer that needs the value later reads the result register, which holds until the next frame completes. The divider is checked when the design is elaborated: the serial clock must lie between 1 MHz and 4 MHz, and each half period must exceed the depth of the data-input synchroniser.

Top module: `als_frame_reader`

## Requirements
- R1: During and after a synchronous reset, `sel_n_o` is 1, `sclk_o` is 1, `valid_o` is 0, and `sample_o` and `frame_err_o` are 0.
- R2: A start request sampled while idle drives `sel_n_o` low on the next cycle. `sclk_o` then stays high for HALF_DIV cycles before its first falling edge.
- R3: Each frame has exactly 16 rising edges of `sclk_o`. Each high phase and each low phase lasts HALF_DIV system cycles.
- R4: `sdi_i` is taken on each rising edge of `sclk_o`. The bits at rising edges 4 to 11 (counted from 1) form `sample_o`, with the bit at edge 4 becoming bit 7.
- R5: `sel_n_o` rises HALF_DIV cycles after the 16th rising edge, with `sclk_o` still high. `valid_o` is 1 in exactly that cycle and in no other.
- R6: `frame_err_o` updates with `valid_o`. It is 1 if any bit taken at rising edges 1 to 3 or 12 to 15 was 1. The bit at edge 16 has no effect.
- R7: `sample_o` and `frame_err_o` hold their values in every cycle in which `valid_o` is 0.
- R8: After `sel_n_o` rises, it stays high for at least 2*HALF_DIV cycles. A start request made while a frame or this hold is in progress is ignored.
- R9: `sdi_i` has no effect while `sel_n_o` is high or before the first rising edge of a frame.
- R10: `sclk_o` is 1 whenever `sel_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to read one sample |
| sel_n_o | output | 1 | Converter select, active low |
| sclk_o | output | 1 | Serial clock to the converter, idles high |
| sdi_i | input | 1 | Serial data from the converter |
| sample_o | output | 8 | Last light reading, 0 darkest to 255 brightest |
| valid_o | output | 1 | One-cycle strobe when a new reading is loaded |
| frame_err_o | output | 1 | Padding bit of the last frame was non-zero |

## Verification
Two events can fall in the same cycle: completion of a frame (the strobe together with the select line rising) and a new start request. The bench provokes this by holding the start request high across a completed frame, while also pulsing start in the middle of a frame. A behavioural timeline model predicts every pin in every cycle. It judges that the request is refused until the select line has been high for the full hold, and that it is taken on the first idle cycle after that. The same model also judges padding faults injected at the first and last checked positions, and at the unchecked final bit.

// File: rtl/als_rd_pkg.sv
package als_rd_pkg;
  // Frame layout: sixteen bit slots, zero padding around the reading.
  localparam int FRAME_LEN    = 16;
  localparam int LEAD_PAD     = 3;
  localparam int SAMPLE_W     = 8;
  localparam int TAIL_CHECKED = FRAME_LEN - LEAD_PAD - SAMPLE_W - 1;
  localparam int IDX_W        = $clog2(FRAME_LEN + 1);

  // Legal serial clock range in Hz.
  localparam int unsigned SCLK_MIN_HZ = 1_000_000;
  localparam int unsigned SCLK_MAX_HZ = 4_000_000;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_RUN  = 2'd2,
    ST_GAP  = 2'd3
  } rd_state_e;
endpackage

// File: rtl/als_half_timer.sv
module als_half_timer #(
  parameter int HALF_DIV = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  output logic tick_o
);
  localparam int CW = $clog2(HALF_DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = !hold_i && (cnt_q == LAST);
endmodule

// File: rtl/als_link_seq.sv
module als_link_seq
  import als_rd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             tick_i,
  output logic             idle_o,
  output logic             sel_n_o,
  output logic             sclk_o,
  output logic             cap_en_o,
  output logic [IDX_W-1:0] cap_idx_o,
  output logic             frame_go_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST_EDGE = IDX_W'(FRAME_LEN);

  rd_state_e        state_q, state_d;
  logic             sel_n_q, sel_n_d;
  logic             sclk_q, sclk_d;
  logic [IDX_W-1:0] rise_q, rise_d;
  logic             gap_half_q, gap_half_d;

  always_comb begin
    state_d    = state_q;
    sel_n_d    = sel_n_q;
    sclk_d     = sclk_q;
    rise_d     = rise_q;
    gap_half_d = gap_half_q;
    cap_en_o   = 1'b0;
    frame_go_o = 1'b0;
    done_o     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d    = ST_LEAD;
          sel_n_d    = 1'b0;
          rise_d     = '0;
          frame_go_o = 1'b1;
        end
      end
      ST_LEAD: begin
        if (tick_i) begin
          sclk_d  = 1'b0;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (tick_i) begin
          if (!sclk_q) begin
            sclk_d   = 1'b1;
            rise_d   = rise_q + 1'b1;
            cap_en_o = 1'b1;
          end else if (rise_q == LAST_EDGE) begin
            sel_n_d    = 1'b1;
            done_o     = 1'b1;
            gap_half_d = 1'b0;
            state_d    = ST_GAP;
          end else begin
            sclk_d = 1'b0;
          end
        end
      end
      ST_GAP: begin
        if (tick_i) begin
          if (gap_half_q) begin
            state_d = ST_IDLE;
          end else begin
            gap_half_d = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      sel_n_q    <= 1'b1;
      sclk_q     <= 1'b1;
      rise_q     <= '0;
      gap_half_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      sel_n_q    <= sel_n_d;
      sclk_q     <= sclk_d;
      rise_q     <= rise_d;
      gap_half_q <= gap_half_d;
    end
  end

  assign idle_o    = (state_q == ST_IDLE);
  assign sel_n_o   = sel_n_q;
  assign sclk_o    = sclk_q;
  assign cap_idx_o = rise_q;
endmodule

// File: rtl/als_frame_capture.sv
module als_frame_capture
  import als_rd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sdi_i,
  input  logic                clear_i,
  input  logic                cap_en_i,
  input  logic [IDX_W-1:0]    cap_idx_i,
  input  logic                done_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                err_o,
  output logic                valid_o
);
  localparam logic [IDX_W-1:0] DATA_FIRST = IDX_W'(LEAD_PAD);
  localparam logic [IDX_W-1:0] DATA_END   = IDX_W'(LEAD_PAD + SAMPLE_W);
  localparam logic [IDX_W-1:0] CHECK_END  = IDX_W'(FRAME_LEN - 1);

  logic sdi_s;

  // Input synchroniser: depth picked by parameter.
  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign sdi_s = sdi_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          sync_q <= '0;
        end else begin
          sync_q <= {sync_q[SYNC_STAGES-2:0], sdi_i};
        end
      end
      assign sdi_s = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  logic [SAMPLE_W-1:0] shift_q;
  logic                pad_bad_q;
  logic                in_data, in_check;

  assign in_data  = (cap_idx_i >= DATA_FIRST) && (cap_idx_i < DATA_END);
  assign in_check = !in_data && (cap_idx_i < CHECK_END);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      shift_q   <= '0;
      pad_bad_q <= 1'b0;
    end else if (cap_en_i) begin
      if (in_data) begin
        shift_q <= {shift_q[SAMPLE_W-2:0], sdi_s};
      end else if (in_check && sdi_s) begin
        pad_bad_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_o <= '0;
      err_o    <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= done_i;
      if (done_i) begin
        sample_o <= shift_q;
        err_o    <= pad_bad_q;
      end
    end
  end
endmodule

// File: rtl/als_frame_reader.sv
module als_frame_reader
  import als_rd_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ  = 100_000_000,
  parameter int          HALF_DIV    = 25,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  output logic                sel_n_o,
  output logic                sclk_o,
  input  logic                sdi_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                valid_o,
  output logic                frame_err_o
);
  localparam int unsigned SCLK_HZ = SYS_CLK_HZ / (2 * HALF_DIV);

  generate
    if (SCLK_HZ < SCLK_MIN_HZ || SCLK_HZ > SCLK_MAX_HZ) begin : g_bad_rate
      $error("serial clock rate out of the 1 to 4 MHz window");
    end
    if (HALF_DIV <= SYNC_STAGES + 1) begin : g_bad_sync
      $error("half period too short for the input synchroniser");
    end
  endgenerate

  logic             tick, idle, cap_en, frame_go, done;
  logic [IDX_W-1:0] cap_idx;

  als_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .hold_i (idle),
    .tick_o (tick)
  );

  als_link_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .tick_i     (tick),
    .idle_o     (idle),
    .sel_n_o    (sel_n_o),
    .sclk_o     (sclk_o),
    .cap_en_o   (cap_en),
    .cap_idx_o  (cap_idx),
    .frame_go_o (frame_go),
    .done_o     (done)
  );

  als_frame_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .sdi_i     (sdi_i),
    .clear_i   (frame_go),
    .cap_en_i  (cap_en),
    .cap_idx_i (cap_idx),
    .done_i    (done),
    .sample_o  (sample_o),
    .err_o     (frame_err_o),
    .valid_o   (valid_o)
  );
endmodule

// File: rtl/als_frame_reader_chk.sv
module als_frame_reader_chk #(
  parameter int HALF_DIV = 25
) (
  input logic       clk,
  input logic       rst,
  input logic       sel_n_o,
  input logic       sclk_o,
  input logic [7:0] sample_o,
  input logic       valid_o,
  input logic       frame_err_o
);
  localparam int HOLD = 2 * HALF_DIV;
  localparam int HW   = $clog2(HOLD + 2);

  logic          sclk_prev_q, sel_prev_q;
  logic [4:0]    rises_q;
  logic [HW-1:0] high_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev_q <= 1'b1;
      sel_prev_q  <= 1'b1;
      rises_q     <= '0;
      high_q      <= HW'(HOLD);
    end else begin
      sclk_prev_q <= sclk_o;
      sel_prev_q  <= sel_n_o;
      if (sel_prev_q && !sel_n_o) begin
        rises_q <= '0;
      end else if (sclk_o && !sclk_prev_q && !sel_n_o) begin
        rises_q <= rises_q + 1'b1;
      end
      if (!sel_n_o) begin
        high_q <= '0;
      end else if (high_q < HW'(HOLD)) begin
        high_q <= high_q + 1'b1;
      end
    end
  end

  assert_idle_clock_high_R10: assert property (@(posedge clk) disable iff (rst)
    sel_n_o |-> sclk_o);

  assert_lead_clock_high_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(sel_n_o) |-> sclk_o);

  assert_sixteen_edges_R3: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (rises_q == 5'd16));

  assert_valid_with_release_R5: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $rose(sel_n_o));

  assert_release_gives_valid_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_n_o) |-> valid_o);

  assert_valid_single_R5: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(sample_o) && $stable(frame_err_o)));

  assert_release_hold_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(sel_n_o) |-> (high_q >= HW'(HOLD)));
endmodule

bind als_frame_reader als_frame_reader_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sel_n_o     (sel_n_o),
  .sclk_o      (sclk_o),
  .sample_o    (sample_o),
  .valid_o     (valid_o),
  .frame_err_o (frame_err_o)
);

// File: tb/als_frame_reader_bench.sv
`timescale 1ns/1ps
module als_frame_reader_bench;
  localparam int H = 25;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       sdi_i = 1'b1;
  logic       sel_n_o, sclk_o, valid_o, frame_err_o;
  logic [7:0] sample_o;

  always #2.5 clk = ~clk;

  als_frame_reader #(.SYS_CLK_HZ(200_000_000), .HALF_DIV(H), .SYNC_STAGES(2))
    u_als_frame_reader (
      .clk(clk), .rst(rst), .start_i(start_i), .sel_n_o(sel_n_o),
      .sclk_o(sclk_o), .sdi_i(sdi_i), .sample_o(sample_o),
      .valid_o(valid_o), .frame_err_o(frame_err_o));

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // Bit slot 0 of the frame is cur_frame[15].
  bit [15:0] cur_frame = 16'h0;

  // Timeline reference model: ft counts cycles since a request was taken.
  int   ft = -1;
  bit   e_sel = 1, e_sclk = 1, e_valid = 0, e_err = 0;
  bit [7:0] e_sample = 0;

  always @(posedge clk) begin
    if (rst) begin
      ft = -1; e_sel = 1; e_sclk = 1; e_valid = 0; e_sample = 0; e_err = 0;
    end else begin
      e_valid = 0;
      if (ft >= 0) begin
        ft++;
        if (ft == 35 * H) ft = -1;
      end else if (start_i) begin
        ft = 0;
      end
      if (ft < 0 || ft >= 33 * H) begin
        e_sel = 1; e_sclk = 1;
      end else begin
        e_sel = 0;
        e_sclk = (ft < H) ? 1'b1 : (((ft - H) % (2 * H)) >= H);
      end
      if (ft == 33 * H) begin
        e_valid  = 1;
        e_sample = cur_frame[12:5];
        e_err    = (cur_frame[15:13] != 0) || (cur_frame[4:1] != 0);
      end
    end
  end

  // Converter model: new bit after each falling clock, ones outside the frame.
  bit prev_sclk = 1;
  int fidx = 0;
  always @(negedge clk) begin
    if (sel_n_o) begin
      fidx = 0;
      sdi_i <= 1'b1;
    end else if (prev_sclk && !sclk_o) begin
      sdi_i <= cur_frame[15 - fidx];
      fidx++;
    end
    prev_sclk = sclk_o;
  end

  task automatic cmp(string tag, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      cmp("R2/R8", "sel_n_o", sel_n_o, e_sel);
      cmp("R3/R10", "sclk_o", sclk_o, e_sclk);
      cmp("R5", "valid_o", valid_o, e_valid);
      cmp("R4/R7/R9", "sample_o", sample_o, e_sample);
      cmp("R6/R7", "frame_err_o", frame_err_o, e_err);
    end
  end

  task automatic wait_idle();
    while (ft >= 0) @(negedge clk);
  endtask

  task automatic one_frame(bit [15:0] f, bit poke);
    wait_idle();
    cur_frame = f;
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    if (poke) begin
      repeat (10 * H) @(negedge clk);
      start_i = 1;          // R8: request mid-frame must be ignored
      @(negedge clk);
      start_i = 0;
    end
    repeat (36 * H) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    cmp("R1", "sel_n_o", sel_n_o, 1);
    cmp("R1", "sclk_o", sclk_o, 1);
    cmp("R1", "valid_o", valid_o, 0);
    cmp("R1", "sample_o", sample_o, 0);
    cmp("R1", "frame_err_o", frame_err_o, 0);
    rst = 0;
    repeat (10) @(negedge clk);

    one_frame({3'b000, 8'hA5, 5'b00000}, 0);   // R4 clean reading
    one_frame({3'b000, 8'hFF, 5'b00000}, 1);   // R4 full scale, R8 poke
    one_frame({3'b000, 8'h00, 5'b00000}, 0);   // R4 darkest
    one_frame({3'b100, 8'h3C, 5'b00000}, 0);   // R6 first lead pad set
    one_frame({3'b000, 8'h81, 5'b00010}, 0);   // R6 last checked tail pad set
    one_frame({3'b000, 8'h5A, 5'b00001}, 0);   // R6 final bit unchecked
    one_frame({3'b000, 8'h01, 5'b00000}, 0);   // R7 error clears

    // R8: start held high across completion and the release hold
    wait_idle();
    cur_frame = {3'b000, 8'hC3, 5'b00000};
    start_i = 1;
    @(negedge clk);
    while (!e_valid) @(negedge clk);
    cur_frame = {3'b010, 8'h7E, 5'b00000};
    @(negedge clk);
    while (!e_valid) @(negedge clk);
    start_i = 0;
    repeat (3 * H) @(negedge clk);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 100_000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule